// File: doc/BRIEF.md
# Two-Input NOR Stuck-Open Fault Tester

This block holds a behavioural model of a two-input CMOS NOR gate and a small sequencer that tests it. The model can carry an open (non-conducting) fault in the pull-down device controlled by input A. With the fault present, the output node is undriven when A is high and B is low. In that case it keeps the value it had on the previous cycle. The gate then stops being combinational and holds state.

A single vector cannot expose this fault, so the sequencer applies an ordered pair. A start pulse makes it drive a priming vector for one cycle. It then drives the detecting vector A=1, B=0 for one cycle. It samples the gate output at the end of that cycle and compares it with the fault-free result, which is 0. The priming vector is selectable. With A=0, B=0 the node is charged high first, so an open device leaves it high and the fault is exposed. With A=1, B=1 the node is already low, so the detecting vector alone reveals nothing. This mode shows why the order of the pair matters.

Top module: `nor_open_fault_tester`

## Requirements
- R1: With `fault_en`=0, `gate_z` equals NOR(`vec_a`, `vec_b`) in every cycle.
- R2: With `fault_en`=1 and `vec_a`=`vec_b`=1, `gate_z` is 0.
- R3: With `fault_en`=1, `vec_a`=1 and `vec_b`=0, `gate_z` equals the value `gate_z` had in the previous clock cycle. The held value is 0 while reset is asserted.
- R4: A `start` seen high while idle drives the priming vector on (`vec_a`,`vec_b`) in the next cycle: (0,0) if `prime_hi`=0, (1,1) if `prime_hi`=1. The cycle after that drives (1,0). In the third cycle the vector returns to (0,0) and `done` is high for exactly that one cycle.
- R5: `fail` becomes 1 in the `done` cycle only if `gate_z` was 1 during the (1,0) cycle. Otherwise it is 0. It keeps its value until the next accepted `start`, which clears it.
- R6: With `fault_en`=0, `fail` is 0 after a run in either priming mode.
- R7: With `fault_en`=1 and `prime_hi`=0, `fail` is 1 after a run.
- R8: With `fault_en`=1 and `prime_hi`=1, `fail` is 0 after a run, because the detecting vector after (1,1) does not expose the fault.
- R9: `start` is ignored while a run is in progress. The sequence is not restarted or lengthened.
- R10: During reset, `vec_a`=`vec_b`=0, `done`=0 and `fail`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a two-vector run when idle |
| fault_en | input | 1 | Makes the A pull-down device open in the gate model |
| prime_hi | input | 1 | Selects priming vector (1,1) instead of (0,0); sampled at start |
| vec_a | output | 1 | Vector bit applied to gate input A |
| vec_b | output | 1 | Vector bit applied to gate input B |
| gate_z | output | 1 | Gate model output node |
| done | output | 1 | One-cycle pulse when the result is ready |
| fail | output | 1 | Sampled output differed from the fault-free value |

## Verification
The assertions assume that `fault_en` stays constant for the whole of a run, from the accepted `start` to `done`. Only under that assumption does a reported failure point to the open device. The stimulus changes `fault_en` and `prime_hi` only between runs, on the falling clock edge. The bench checks every output against a cycle-level reference model on each clock. It also sends extra `start` pulses in the middle of runs, so the rule that a busy sequencer ignores them is covered.

// File: rtl/nor_open_pkg.sv
package nor_open_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PRIME = 2'd1,
        SEQ_PROBE = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       vec_a;
        logic       vec_b;
        logic       done;
        logic       fail;
    } seq_regs_t;

    localparam logic PROBE_A      = 1'b1;
    localparam logic PROBE_B      = 1'b0;
    localparam logic GOOD_PROBE_Z = 1'b0;

endpackage

// File: rtl/nor2_open_model.sv
module nor2_open_model #(
    parameter logic HOLD_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    input  logic open_a,
    output logic node_z
);
    typedef struct packed {
        logic held;
    } node_regs_t;

    node_regs_t r_q, r_d;
    logic pull_up, pull_dn;

    always_comb begin
        pull_up = !in_a && !in_b;
        pull_dn = in_b || (in_a && !open_a);
        if (pull_up)      node_z = 1'b1;
        else if (pull_dn) node_z = 1'b0;
        else              node_z = r_q.held;
        r_d      = r_q;
        r_d.held = node_z;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{held: HOLD_RESET};
        else        r_q <= r_d;
    end

    always_comb begin
        if (!open_a) AST_FREE_NOR: assert (node_z == !(in_a || in_b)); // R1
        if (in_a && in_b) AST_BOTH_HIGH_LOW: assert (node_z == 1'b0); // R2
    end

    AST_FLOAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (open_a && in_a && !in_b && $past(rst_n)) |-> (node_z == $past(node_z))); // R3

endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer
    import nor_open_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic prime_hi,
    input  logic sense_z,
    output logic drv_a,
    output logic drv_b,
    output logic done,
    output logic fail
);
    seq_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    r_d.state = SEQ_PRIME;
                    r_d.vec_a = prime_hi;
                    r_d.vec_b = prime_hi;
                    r_d.fail  = 1'b0;
                end
            end
            SEQ_PRIME: begin
                r_d.state = SEQ_PROBE;
                r_d.vec_a = PROBE_A;
                r_d.vec_b = PROBE_B;
            end
            SEQ_PROBE: begin
                r_d.state = SEQ_IDLE;
                r_d.fail  = (sense_z != GOOD_PROBE_Z);
                r_d.done  = 1'b1;
                r_d.vec_a = 1'b0;
                r_d.vec_b = 1'b0;
            end
            default: r_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: SEQ_IDLE, vec_a: 1'b0, vec_b: 1'b0, done: 1'b0, fail: 1'b0};
        else        r_q <= r_d;
    end

    assign drv_a = r_q.vec_a;
    assign drv_b = r_q.vec_b;
    assign done  = r_q.done;
    assign fail  = r_q.fail;

    AST_DONE_AFTER_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(drv_a) && !$past(drv_b))); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_FAIL_RISES_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> done); // R5
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_a && !drv_b) |=> !(drv_a || drv_b)); // R9

endmodule

// File: rtl/nor_open_fault_tester.sv
module nor_open_fault_tester (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fault_en,
    input  logic prime_hi,
    output logic vec_a,
    output logic vec_b,
    output logic gate_z,
    output logic done,
    output logic fail
);
    logic seq_a, seq_b, node_z;

    pattern_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .prime_hi (prime_hi),
        .sense_z  (node_z),
        .drv_a    (seq_a),
        .drv_b    (seq_b),
        .done     (done),
        .fail     (fail)
    );

    nor2_open_model #(.HOLD_RESET(1'b0)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_a   (seq_a),
        .in_b   (seq_b),
        .open_a (fault_en),
        .node_z (node_z)
    );

    assign vec_a  = seq_a;
    assign vec_b  = seq_b;
    assign gate_z = node_z;

    AST_HEALTHY_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault_en) |-> !fail); // R6

    always_comb begin
        if (!rst_n) AST_RESET_QUIET: assert (!vec_a && !vec_b && !done && !fail); // R10
    end

endmodule

// File: tb/sim_nor_open_fault_tester.sv
module sim_nor_open_fault_tester;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, fault_en = 1'b0, prime_hi = 1'b0;
    logic vec_a, vec_b, gate_z, done, fail;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    int   m_ph = 0;
    logic m_a = 0, m_b = 0, m_held = 0, m_done = 0, m_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_open_fault_tester u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fault_en(fault_en), .prime_hi(prime_hi),
        .vec_a(vec_a), .vec_b(vec_b), .gate_z(gate_z), .done(done), .fail(fail)
    );

    function automatic logic model_z(logic a, logic b, logic fen, logic held);
        if (!a && !b) return 1'b1;
        if (b) return 1'b0;
        if (a && !fen) return 1'b0;
        return held;
    endfunction

    task automatic check(string tag, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R4 vec_a", vec_a, m_a);
        check("R4 vec_b", vec_b, m_b);
        check("R1 R2 R3 gate_z", gate_z, model_z(m_a, m_b, fault_en, m_held));
        check("R4 done", done, m_done);
        check("R5 fail", fail, m_fail);
    endtask

    task automatic step(logic st, logic fen, logic phi);
        logic zn;
        @(negedge clk);
        compare_all();
        start = st; fault_en = fen; prime_hi = phi;
        zn = model_z(m_a, m_b, fen, m_held);
        m_held = zn;
        if (m_ph == 0) begin
            m_done = 0;
            if (st) begin
                m_a = phi; m_b = phi; m_fail = 0; m_ph = 1;
            end
        end else if (m_ph == 1) begin
            m_a = 1; m_b = 0; m_ph = 2;
        end else begin
            m_fail = (zn != 1'b0); m_done = 1; m_a = 0; m_b = 0; m_ph = 0;
        end
    endtask

    task automatic run(logic fen, logic phi, bit busy_starts, string tag, logic exp_fail);
        step(1, fen, phi);
        step(busy_starts, fen, phi);
        step(busy_starts, fen, phi);
        step(0, fen, phi);
        @(negedge clk);
        check(tag, fail, exp_fail);
        check("R4 idle after run", done, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 vec_a", vec_a, 1'b0);
        check("R10 vec_b", vec_b, 1'b0);
        check("R10 done", done, 1'b0);
        check("R10 fail", fail, 1'b0);
        rst_n = 1'b1;
        step(0, 0, 0);
        step(0, 0, 0);
        run(0, 0, 0, "R6 healthy prime00", 1'b0);
        run(0, 1, 0, "R6 healthy prime11", 1'b0);
        run(1, 0, 0, "R7 open prime00", 1'b1);
        run(1, 1, 0, "R8 open prime11 masks", 1'b0);
        run(1, 0, 1, "R9 R7 busy starts ignored", 1'b1);
        run(1, 1, 1, "R5 fail cleared R8", 1'b0);
        run(0, 0, 1, "R9 R6 busy healthy", 1'b0);
        step(0, 1, 0);
        step(0, 1, 0);
        step(0, 0, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule